// File: doc/BRIEF.md
# Fixed-Point Cubic Polynomial Evaluator

This block evaluates the cubic y = -0.1666·x³ + 2.5·x² - 21.666·x + 36.6653 on a 16-bit two's-complement integer operand. It uses only integer multipliers and adders. Every fractional coefficient is held as a signed integer scaled by 2^16, and the binary point is tracked explicitly through the datapath. The block accepts one operand per clock, marked by an input valid strobe. Three cycles later it presents a 16-bit signed result with its own valid strobe.

Intermediate widths grow with each product, so nothing overflows before the final step. A signed product of N and M bits is exactly N+M bits wide. The cube is 48 bits wide, and every term is sign-extended to a 72-bit sum. The sum is rounded to the nearest integer. Sums outside the 16-bit range clamp to the nearest extreme instead of wrapping. This matters for large operands: at x = -32767 the exact value is about 5.9·10^12.

Top module: `cubic_poly_eval`

## Requirements
- R1: `out_vld` is high in exactly those cycles that follow, by three rising clock edges, a cycle in which `in_vld` was sampled high with `rst` low, so the latency is fixed at three cycles.
- R2: With the scaled constants A3 = -10918, A2 = 163840, A1 = -1419903, A0 = 2402897 (each the coefficient times 65536, rounded), the result is derived from S = A3·x³ + A2·x² + A1·x + A0 computed without overflow. For example, x = 0 gives 37 and x = 1 gives 17.
- R3: Rounding adds 32768 to S and then shifts arithmetically right by 16 bits, so ties go toward positive infinity. A fraction of S at or above one half (S mod 65536 ≥ 32768) rounds up.
- R4: A rounded value above 32767 is output as 32767 (0x7FFF), and one below -32768 is output as -32768 (0x8000). For example, x = -32767 gives 32767 and x = 32767 gives -32768.
- R5: A synchronous active-high `rst` drops `out_vld` at the next edge and discards every operand in flight. It does not clear the arithmetic registers.
- R6: Operands presented on consecutive cycles each produce their own result, on consecutive cycles and in the same order.
- R7: `out_y` keeps its value in every cycle in which `out_vld` is low, whatever `in_x` does while `in_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_vld | input | 1 | Marks `in_x` as an operand to evaluate |
| in_x | input | 16 | Signed integer operand |
| out_vld | output | 1 | Marks `out_y` as a fresh result |
| out_y | output | 16 | Rounded and saturated signed result |

## Verification
Zero, ±1 and small even operands check the coefficient scaling and signs against known small results. Operands swept for a fraction of one half or more separate round-half-up from plain truncation. The two 16-bit extremes, and magnitudes of a few thousand, drive the sum past both limits, which exposes wrapping in place of clamping. A back-to-back burst checks ordering and single-cycle throughput. Idle gaps with a toggling operand, and a reset with results in flight, check the hold and discard behaviour.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

    localparam int X_W    = 16;
    localparam int FRAC_W = 16;
    localparam int COEF_W = 24;
    localparam int SQ_W   = 2 * X_W;
    localparam int CUBE_W = 3 * X_W;
    localparam int T2_W   = SQ_W + COEF_W;
    localparam int T1_W   = X_W + COEF_W;
    localparam int ACC_W  = CUBE_W + COEF_W;

    // Coefficients scaled by 2**FRAC_W and rounded to integers.
    localparam logic signed [COEF_W-1:0] K3 = -24'sd10918;
    localparam logic signed [COEF_W-1:0] K2 =  24'sd163840;
    localparam logic signed [COEF_W-1:0] K1 = -24'sd1419903;
    localparam logic signed [COEF_W-1:0] K0 =  24'sd2402897;

    typedef struct packed {
        logic signed [X_W-1:0]  x;
        logic signed [SQ_W-1:0] sq;
    } sq_stage_t;

    typedef struct packed {
        logic signed [CUBE_W-1:0] cube;
        logic signed [T2_W-1:0]   t2;
        logic signed [T1_W-1:0]   t1;
    } prod_stage_t;

    // Add half an LSB, then drop the fraction (ties go up).
    function automatic logic signed [ACC_W-1:0] round_half_up(
        input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] half;
        half = ACC_W'(1) <<< (FRAC_W - 1);
        return (v + half) >>> FRAC_W;
    endfunction

    // Clamp a wide signed integer into the X_W-bit output range.
    function automatic logic signed [X_W-1:0] clamp_out(
        input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = {{(ACC_W-X_W+1){1'b0}}, {(X_W-1){1'b1}}};
        lo = {{(ACC_W-X_W+1){1'b1}}, {(X_W-1){1'b0}}};
        if (v > hi)      return hi[X_W-1:0];
        else if (v < lo) return lo[X_W-1:0];
        else             return v[X_W-1:0];
    endfunction

endpackage

// File: rtl/cpe_square.sv
module cpe_square
    import cpe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic signed [X_W-1:0] in_x,
    output logic                  s1_vld,
    output sq_stage_t             s1
);
    logic signed [SQ_W-1:0] x_ext;
    logic signed [SQ_W-1:0] sq_c;

    always_comb begin
        x_ext = SQ_W'(in_x);
        sq_c  = x_ext * x_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_vld <= 1'b0;
        else     s1_vld <= in_vld;
        if (in_vld && !rst) begin
            s1.x  <= in_x;
            s1.sq <= sq_c;
        end
    end
endmodule

// File: rtl/cpe_products.sv
module cpe_products
    import cpe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        s1_vld,
    input  sq_stage_t   s1,
    output logic        s2_vld,
    output prod_stage_t s2
);
    logic signed [CUBE_W-1:0] cube_c;
    logic signed [T2_W-1:0]   t2_c;
    logic signed [T1_W-1:0]   t1_c;

    always_comb begin
        cube_c = CUBE_W'($signed(s1.sq)) * CUBE_W'($signed(s1.x));
        t2_c   = T2_W'($signed(s1.sq)) * T2_W'(K2);
        t1_c   = T1_W'($signed(s1.x)) * T1_W'(K1);
    end

    always_ff @(posedge clk) begin
        if (rst) s2_vld <= 1'b0;
        else     s2_vld <= s1_vld;
        if (s1_vld && !rst) begin
            s2.cube <= cube_c;
            s2.t2   <= t2_c;
            s2.t1   <= t1_c;
        end
    end
endmodule

// File: rtl/cpe_sum.sv
module cpe_sum
    import cpe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s2_vld,
    input  prod_stage_t           s2,
    output logic                  out_vld,
    output logic signed [X_W-1:0] out_y
);
    logic signed [ACC_W-1:0] t3_c;
    logic signed [ACC_W-1:0] sum_c;
    logic signed [ACC_W-1:0] int_c;
    logic signed [X_W-1:0]   sat_c;

    always_comb begin
        t3_c  = ACC_W'($signed(s2.cube)) * ACC_W'(K3);
        sum_c = t3_c + ACC_W'($signed(s2.t2)) + ACC_W'($signed(s2.t1)) + ACC_W'(K0);
        int_c = round_half_up(sum_c);
        sat_c = clamp_out(int_c);
    end

    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= s2_vld;
        if (s2_vld && !rst) out_y <= sat_c;
    end
endmodule

// File: rtl/cubic_poly_eval.sv
module cubic_poly_eval
    import cpe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic signed [15:0]    in_x,
    output logic                  out_vld,
    output logic signed [15:0]    out_y
);
    logic        s1_vld;
    sq_stage_t   s1;
    logic        s2_vld;
    prod_stage_t s2;

    cpe_square u_sq (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x),
        .s1_vld(s1_vld), .s1(s1)
    );

    cpe_products u_prod (
        .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1(s1),
        .s2_vld(s2_vld), .s2(s2)
    );

    cpe_sum u_sum (
        .clk(clk), .rst(rst), .s2_vld(s2_vld), .s2(s2),
        .out_vld(out_vld), .out_y(out_y)
    );
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker (
    input logic               clk,
    input logic               rst,
    input logic               in_vld,
    input logic signed [15:0] in_x,
    input logic               out_vld,
    input logic signed [15:0] out_y
);
    logic [2:0]        vh;
    logic signed [15:0] xh [3];

    always_ff @(posedge clk) begin
        if (rst) vh <= '0;
        else     vh <= {vh[1:0], in_vld};
        xh[0] <= in_x;
        xh[1] <= xh[0];
        xh[2] <= xh[1];
    end

    // R1: output strobe trails input strobe by three edges
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        out_vld == vh[2]);

    // R5: reset drops the output strobe at the next edge
    p_reset_drop_r5: assert property (@(posedge clk)
        rst |=> !out_vld);

    // R2: zero operand yields 37
    p_zero_value_r2: assert property (@(posedge clk) disable iff (rst)
        (out_vld && xh[2] == 16'sd0) |-> out_y == 16'sd37);

    // R2: unit operand yields 17
    p_unit_value_r2: assert property (@(posedge clk) disable iff (rst)
        (out_vld && xh[2] == 16'sd1) |-> out_y == 16'sd17);

    // R4: largest positive operand clamps low
    p_clamp_low_r4: assert property (@(posedge clk) disable iff (rst)
        (out_vld && xh[2] == 16'sh7FFF) |-> out_y == 16'sh8000);

    // R4: most negative operands clamp high
    p_clamp_high_r4: assert property (@(posedge clk) disable iff (rst)
        (out_vld && xh[2][15]) && xh[2] < -16'sd2000 |-> out_y == 16'sh7FFF);
endmodule

bind cubic_poly_eval cpe_checker u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x),
    .out_vld(out_vld), .out_y(out_y)
);

// File: tb/sim_cubic_poly_eval.sv
`timescale 1ns/1ps
module sim_cubic_poly_eval;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_vld = 1'b0;
    logic signed [15:0] in_x = '0;
    logic               out_vld;
    logic signed [15:0] out_y;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag_v = "R1";
    string tag_d = "R2";
    logic               hv [3] = '{1'b0, 1'b0, 1'b0};
    logic signed [15:0] hx [3] = '{16'sd0, 16'sd0, 16'sd0};
    logic               have_last = 1'b0;
    logic signed [15:0] last_y = '0;
    logic               done = 1'b0;

    always #2.5 clk = ~clk;

    cubic_poly_eval u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x),
        .out_vld(out_vld), .out_y(out_y)
    );

    function automatic logic signed [127:0] poly_s(input logic signed [15:0] x);
        logic signed [127:0] v;
        v = x;
        return -(128'sd10918) * v * v * v + 128'sd163840 * v * v
               - 128'sd1419903 * v + 128'sd2402897;
    endfunction

    function automatic logic signed [15:0] ref_y(input logic signed [15:0] x);
        logic signed [127:0] r;
        r = (poly_s(x) + 128'sd32768) >>> 16;
        if (r > 128'sd32767)  return 16'sh7FFF;
        if (r < -128'sd32768) return 16'sh8000;
        return r[15:0];
    endfunction

    function automatic bit rounds_up(input logic signed [15:0] x);
        logic signed [127:0] s;
        s = poly_s(x);
        return s[15:0] >= 16'h8000;
    endfunction

    task automatic check_outputs();
        logic signed [15:0] e;
        n_chk++;
        if (out_vld !== hv[2]) begin
            n_bad++;
            $display("FAIL %s: out_vld=%b expected %b", tag_v, out_vld, hv[2]);
        end
        if (hv[2]) begin
            e = ref_y(hx[2]);
            n_chk++;
            if (out_y !== e) begin
                n_bad++;
                $display("FAIL %s: x=%0d out_y=%0d expected %0d", tag_d, hx[2], out_y, e);
            end
            last_y    = e;
            have_last = 1'b1;
        end else if (have_last) begin
            n_chk++;   // R7 hold
            if (out_y !== last_y) begin
                n_bad++;
                $display("FAIL R7: out_y=%0d expected held %0d", out_y, last_y);
            end
        end
    endtask

    task automatic tick(input logic v, input logic signed [15:0] x, input logic r);
        @(negedge clk);
        check_outputs();
        rst = r; in_vld = v; in_x = x;
        if (r) begin
            hv[0] = 1'b0; hv[1] = 1'b0; hv[2] = 1'b0;
        end else begin
            hv[2] = hv[1]; hx[2] = hx[1];
            hv[1] = hv[0]; hx[1] = hx[0];
            hv[0] = v;     hx[0] = x;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        tag_v = "R5";
        repeat (4) tick(1'b0, 16'sd0, 1'b1);
        repeat (3) tick(1'b0, 16'sd0, 1'b0);

        // R2: small operands with gaps
        tag_v = "R1"; tag_d = "R2";
        foreach (hx[i]) ; // no-op keep structure simple
        begin
            logic signed [15:0] pts [10] = '{0, 1, -1, 2, 4, 6, -2, -4, 10, 100};
            foreach (pts[i]) begin
                tick(1'b1, pts[i], 1'b0);
                tick(1'b0, pts[i] + 16'sd7, 1'b0);
            end
        end

        // R3: operands whose fraction rounds upward
        tag_d = "R3";
        begin
            int cnt = 0;
            for (int xi = -200; xi <= 200 && cnt < 20; xi++) begin
                if (rounds_up(16'(xi))) begin
                    tick(1'b1, 16'(xi), 1'b0);
                    cnt++;
                end
            end
        end
        repeat (4) tick(1'b0, 16'sd0, 1'b0);

        // R4: saturation at both ends
        tag_d = "R4";
        begin
            logic signed [15:0] big [7] = '{32767, -32768, -32767, 32766, 1000, -1000, 5000};
            foreach (big[i]) tick(1'b1, big[i], 1'b0);
        end
        repeat (4) tick(1'b0, 16'sd0, 1'b0);

        // R6: back-to-back burst
        tag_d = "R6";
        for (int k = 0; k < 30; k++) tick(1'b1, 16'(k * 37 - 500), 1'b0);

        // R7: idle with toggling operand
        for (int k = 0; k < 8; k++) tick(1'b0, 16'(k * 4099), 1'b0);

        // R5: reset with results in flight
        tag_v = "R5"; tag_d = "R5";
        tick(1'b1, 16'sd3, 1'b0);
        tick(1'b1, 16'sd5, 1'b0);
        tick(1'b1, 16'sd9, 1'b1);
        tick(1'b0, 16'sd0, 1'b0);
        repeat (4) tick(1'b0, 16'sd11, 1'b0);
        tick(1'b1, 16'sd8, 1'b0);
        repeat (5) tick(1'b0, 16'sd0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule